// File: doc/BRIEF.md
# Full-Duplex SPI Master with Level Interrupts

This block is a synchronous serial master that moves words between a small register interface and an SPI bus in mode 0. The serial clock idles low, data leaves on `mosi` most significant bit first, and `miso` is captured on each rising clock edge. Software pushes words into an eight-entry transmit queue and pops received words from an eight-entry receive queue. While the block is enabled, a frame starts whenever the transmit queue holds a word. The serial clock therefore only toggles while data is being shifted. Chip select is driven outside the block.

A programmable prescaler and a rate field set the bit rate. A size field sets the frame length, from 4 to 16 bits. One interrupt line is the OR of three conditions, each with its own mask: the transmit queue is at or below half full, the receive queue is at or above half full, and a sticky receive overrun. The shift engine is a four-state machine:
- `ST_IDLE`: clock low.
- `ST_LOW`: clock low, output bit valid.
- `ST_HIGH`: clock high.
- `ST_DONE`: the received word is handed to the receive queue.

Its transitions are:
- `ST_IDLE` to `ST_LOW` when the block is enabled and the transmit queue is not empty. The word is popped and loaded.
- `ST_LOW` to `ST_HIGH` when a half-period elapses. The input bit is sampled.
- `ST_HIGH` to `ST_LOW` when a half-period elapses and bits remain. The output shifts.
- `ST_HIGH` to `ST_DONE` when a half-period elapses on the last bit.
- `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `spim_ctrl`

## Requirements
- R1: Register offsets:
  - 0 is control. Bits [3:0] hold the frame length minus one, bit 4 is enable, bit 5 masks in the transmit-level interrupt, bit 6 the receive-level interrupt, bit 7 the overrun interrupt, and bits [15:8] are the rate field.
  - 1 is prescale.
  - 2 is data.
  - 3 is status.
  - 4 is interrupt status and overrun clear.
  
  After reset:
  - control reads 0x0007 and prescale reads 2;
  - status reads 0x0023;
  - `irq` and `sclk` are low.
- R2: In mode 0, with enable set and the transmit queue non-empty, a frame starts on its own. `mosi` carries the word MSB first and changes only while `sclk` is low. With enable clear or no transmit data, `sclk` stays low and no frame is sent.
- R3: A frame is control[3:0]+1 bits long. Values below 3 act as 3, giving 4 bits. The received word is right-justified with zeros above the frame length.
- R4: One serial clock period lasts P*(1+rate) system clocks. P is the prescale value with bit 0 cleared, and a value below 2 is taken as 2.
- R5: Each queue holds 8 words in first-in first-out order. A data write into a full transmit queue is dropped. A data read from an empty receive queue returns 0 and removes nothing.
- R6: Status busy is high while a frame is in flight or the transmit queue is non-empty.
- R7: Status bits:
  - 0: transmit queue empty
  - 1: transmit queue not full
  - 2: receive queue not empty
  - 3: receive queue full
  - 4: busy
  - 5: transmit level
  - 6: receive level
  - 7: overrun
- R8: The transmit level holds when the transmit queue has 4 or fewer words. The receive level holds when the receive queue has 4 or more.
- R9: A word completed while the receive queue is full is discarded and sets a sticky overrun flag. Only a write to offset 4 clears it.
- R10: `irq` is the OR of the three conditions, each ANDed with its mask bit. Offset 4 reads the masked transmit level in bit 0, the masked receive level in bit 1 and the masked overrun in bit 2.
- R11: Clearing enable during a frame lets that frame finish. No further frame starts, and the queued transmit words stay in order until enable is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Combined interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A data write lands in the transmit queue at the next clock edge. The engine leaves `ST_IDLE` one edge later. The first rising serial edge follows after one half-period, and the received word enters the receive queue two half-periods per bit later plus one cycle in `ST_DONE`. Status, interrupt and read data are combinational from registers, so they are valid a cycle after the edge that changed them. The bench therefore polls the busy flag until it drops before it reads results, and samples every output one nanosecond after a falling clock edge. Clock-rate checks measure the time between consecutive rising serial edges directly, and serial traffic is captured by a bench slave on `sclk` edges.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } eng_state_t;

    localparam int unsigned REG_AW = 3;
    localparam logic [REG_AW-1:0] A_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] A_PRESC = 3'd1;
    localparam logic [REG_AW-1:0] A_DATA  = 3'd2;
    localparam logic [REG_AW-1:0] A_STAT  = 3'd3;
    localparam logic [REG_AW-1:0] A_IRQ   = 3'd4;

    // control field positions
    localparam int C_EN   = 4;
    localparam int C_MTX  = 5;
    localparam int C_MRX  = 6;
    localparam int C_MOVR = 7;
    localparam int C_RATE = 8;
    localparam int RATE_W = 8;

    localparam logic [15:0] CTRL_RST = 16'h0007;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            end
            if (do_pop) begin
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
            end
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/spim_baud.sv
`timescale 1ns/1ps
module spim_baud #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] half_len,
    output logic          tick
);
    logic [CW-1:0] cnt_q;

    // half_len is never below 1 (guaranteed by the top)
    assign tick = run && (cnt_q >= half_len - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/spim_engine.sv
`timescale 1ns/1ps
module spim_engine
    import spim_pkg::*;
#(
    parameter int DW = 16,
    localparam int LW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [LW-1:0] fsize,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_word,
    output logic          tx_pop,
    input  logic          tick,
    output logic          run,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          rx_push,
    output logic [DW-1:0] rx_word,
    output logic          active
);
    localparam logic [LW-1:0] MIN_M1 = LW'(3);

    eng_state_t    state_q, state_d;
    logic [DW-1:0] tx_sh_q, rx_sh_q;
    logic [LW-1:0] left_q;
    logic [LW-1:0] fs_eff;
    logic          start;

    assign fs_eff = (fsize < MIN_M1) ? MIN_M1 : fsize;
    assign start  = enable && !tx_empty;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOW;
            ST_LOW:  if (tick)  state_d = ST_HIGH;
            ST_HIGH: if (tick)  state_d = (left_q == '0) ? ST_DONE : ST_LOW;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        tx_sh_q <= tx_word << (DW - 1 - int'(fs_eff));
                        rx_sh_q <= '0;
                        left_q  <= fs_eff;
                    end
                end
                ST_LOW: begin
                    if (tick) begin
                        rx_sh_q <= {rx_sh_q[DW-2:0], miso};
                    end
                end
                ST_HIGH: begin
                    if (tick && (left_q != '0)) begin
                        tx_sh_q <= tx_sh_q << 1;
                        left_q  <= left_q - LW'(1);
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        tx_pop  = (state_q == ST_IDLE) && start;
        run     = (state_q == ST_LOW) || (state_q == ST_HIGH);
        sclk    = (state_q == ST_HIGH);
        mosi    = run ? tx_sh_q[DW-1] : 1'b0;
        rx_push = (state_q == ST_DONE);
        rx_word = rx_sh_q;
        active  = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int PW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    localparam int LW   = $clog2(DW);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HW   = PW + RATE_W;
    localparam int HALF = DEPTH / 2;

    logic [15:0]       ctrl_q;
    logic [PW-1:0]     presc_q;
    logic              ovr_q;

    logic              wr_ctrl, wr_presc, wr_data, rd_data, clr_ovr;
    logic [DW-1:0]     tx_dout, rx_dout, rx_word;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              tx_pop, rx_push, run, tick, active, busy;
    logic              tx_lo, rx_hi;
    logic [PW-1:0]     presc_eff;
    logic [RATE_W:0]   rate_p1;
    logic [HW-1:0]     half_len;
    logic [7:0]        stat;
    logic [2:0]        pend;

    assign wr_ctrl  = reg_en && reg_wr && (reg_addr == A_CTRL);
    assign wr_presc = reg_en && reg_wr && (reg_addr == A_PRESC);
    assign wr_data  = reg_en && reg_wr && (reg_addr == A_DATA);
    assign clr_ovr  = reg_en && reg_wr && (reg_addr == A_IRQ);
    assign rd_data  = reg_en && !reg_wr && (reg_addr == A_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            presc_q <= PW'(2);
            ovr_q   <= 1'b0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= reg_wdata[15:0];
            if (wr_presc) presc_q <= reg_wdata[PW-1:0];
            if (rx_push && rx_full) begin
                ovr_q <= 1'b1;
            end else if (clr_ovr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    // bit-rate divisor: half period = (P/2) * (1 + rate)
    assign presc_eff = (presc_q < PW'(2)) ? PW'(2) : {presc_q[PW-1:1], 1'b0};
    assign rate_p1   = {1'b0, ctrl_q[C_RATE +: RATE_W]} + (RATE_W+1)'(1);
    assign half_len  = HW'(presc_eff >> 1) * HW'(rate_p1);

    spim_fifo #(.W(DW), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst_n(rst_n),
        .push(wr_data), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_dout),
        .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    spim_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_word),
        .pop(rd_data), .dout(rx_dout),
        .full(rx_full), .empty(rx_empty), .count(rx_cnt)
    );

    spim_baud #(.CW(HW)) u_baud (
        .clk(clk), .rst_n(rst_n),
        .run(run), .half_len(half_len), .tick(tick)
    );

    spim_engine #(.DW(DW)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .enable(ctrl_q[C_EN]), .fsize(ctrl_q[LW-1:0]),
        .tx_empty(tx_empty), .tx_word(tx_dout), .tx_pop(tx_pop),
        .tick(tick), .run(run),
        .sclk(sclk), .mosi(mosi), .miso(miso),
        .rx_push(rx_push), .rx_word(rx_word), .active(active)
    );

    assign busy  = active || !tx_empty;
    assign tx_lo = (tx_cnt <= CW'(HALF));
    assign rx_hi = (rx_cnt >= CW'(HALF));
    assign stat  = {ovr_q, rx_hi, tx_lo, busy, rx_full, !rx_empty, !tx_full, tx_empty};
    assign pend  = {ovr_q & ctrl_q[C_MOVR], rx_hi & ctrl_q[C_MRX], tx_lo & ctrl_q[C_MTX]};
    assign irq   = |pend;

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = DW'(ctrl_q);
            A_PRESC: reg_rdata = DW'(presc_q);
            A_DATA:  reg_rdata = rx_empty ? '0 : rx_dout;
            A_STAT:  reg_rdata = DW'(stat);
            A_IRQ:   reg_rdata = DW'(pend);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spim_chk.sv
`timescale 1ns/1ps
module spim_chk #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sclk,
    input logic          mosi,
    input logic          irq,
    input logic          busy,
    input logic          ovr,
    input logic          clr,
    input logic [2:0]    masks,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt
);
    // R6: serial clock high only while busy
    a_r6_sclk_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> busy);

    // R5: queues never exceed their depth
    a_r5_tx_depth: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));
    a_r5_rx_depth: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    // R2: mode 0 output held while clock high
    a_r2_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> (!sclk || $stable(mosi)));

    // R9: overrun is sticky until cleared and only rises on a full queue
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !clr) |=> ovr);
    a_r9_ovr_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(rx_cnt) == CW'(DEPTH)));

    // R10: no interrupt with every mask clear
    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (masks == 3'b000) |-> !irq);

    // R3: at most one word enters the receive queue per cycle
    a_r3_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, rx_cnt} <= {1'b0, $past(rx_cnt)} + (CW+1)'(1));
endmodule

bind spim_ctrl spim_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .irq(irq),
    .busy(busy), .ovr(ovr_q), .clr(clr_ovr), .masks(ctrl_q[7:5]),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/tb_spim_ctrl.sv
`timescale 1ns/1ps
module tb_spim_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, sclk, mosi, miso;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    spim_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // ---------------- bench slave ----------------
    int          cur_len = 8;
    int          idx = 0;
    int          frames = 0;
    int          edges = 0;
    logic [15:0] cap = '0;
    logic [15:0] last_mosi = '0;
    logic [15:0] slv;

    function automatic logic [15:0] pat(int k);
        return 16'hC3A5 ^ 16'(k * 4951);
    endfunction

    function automatic logic [15:0] msk(int len);
        return (len >= 16) ? 16'hFFFF : ((16'(1) << len) - 16'(1));
    endfunction

    function automatic logic [15:0] mkctrl(int fs, bit en, bit mtx, bit mrx, bit movr, int rate);
        return {8'(rate), movr, mrx, mtx, en, 4'(fs)};
    endfunction

    assign slv  = pat(frames);
    assign miso = slv[4'(cur_len - 1 - idx)];

    always @(posedge sclk) begin
        cap = {cap[14:0], mosi};
        edges++;
        idx++;
        if (idx == cur_len) begin
            last_mosi = cap;
            cap = '0;
            idx = 0;
            frames++;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd3, s);
            if (s[4] == 1'b0) break;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        logic [15:0] v;
        rd(3'd0, v); chk("R1 ctrl reset", v, 16'h0007);
        rd(3'd1, v); chk("R1 presc reset", v, 16'h0002);
        rd(3'd3, v); chk("R1 R7 status reset", v, 16'h0023);
        chk("R1 irq reset", irq, 0);
        chk("R1 sclk reset", sclk, 0);
        rd(3'd2, v); chk("R5 empty read", v, 0);
    endtask

    task automatic t_basic();
        logic [15:0] v;
        int f0;
        cur_len = 8;
        wr(3'd0, mkctrl(7, 1, 0, 0, 0, 0));
        f0 = frames;
        wr(3'd2, 16'h00A5);
        wait_idle();
        chk("R2 one frame", frames - f0, 1);
        chk("R2 mosi word", last_mosi, 16'h00A5);
        chk("R2 sclk idle low", sclk, 0);
        rd(3'd3, v); chk("R7 rx not empty", v[2], 1);
        rd(3'd2, v); chk("R3 rx word", v, pat(f0) & 16'h00FF);
        rd(3'd3, v); chk("R7 rx empty after read", v[2], 0);
    endtask

    task automatic t_lengths();
        int fsl[3] = '{15, 3, 1};
        logic [15:0] v;
        foreach (fsl[i]) begin
            int len = (fsl[i] < 3) ? 4 : fsl[i] + 1;
            int f0, e0;
            wr(3'd0, mkctrl(fsl[i], 1, 0, 0, 0, 0));
            cur_len = len;
            f0 = frames; e0 = edges;
            wr(3'd2, 16'hBEEF);
            wait_idle();
            chk("R3 edge count", edges - e0, len);
            chk("R3 mosi bits", last_mosi, 16'hBEEF & msk(len));
            rd(3'd2, v); chk("R3 rx justified", v, pat(f0) & msk(len));
        end
    endtask

    task automatic t_rate();
        int pr[4] = '{2, 4, 5, 0};
        int rt[4] = '{0, 2, 0, 2};
        int ex[4] = '{2, 12, 4, 6};
        logic [15:0] v;
        time t1, t2;
        foreach (pr[i]) begin
            wr(3'd1, 16'(pr[i]));
            wr(3'd0, mkctrl(15, 1, 0, 0, 0, rt[i]));
            cur_len = 16;
            wr(3'd2, 16'h1234);
            @(posedge sclk); t1 = $time;
            @(posedge sclk); t2 = $time;
            chk("R4 sclk period", 32'((t2 - t1) / 20), ex[i]);
            wait_idle();
            rd(3'd2, v);
        end
        wr(3'd1, 16'd2);
    endtask

    task automatic t_overrun();
        logic [15:0] v;
        int f0;
        cur_len = 8;
        wr(3'd0, mkctrl(7, 0, 0, 0, 0, 0));
        for (int i = 0; i < 9; i++) wr(3'd2, 16'h0010 + 16'(i));
        rd(3'd3, v);
        chk("R5 tx full flag", v[1], 0);
        chk("R8 tx level off at 8", v[5], 0);
        chk("R6 busy with queued data", v[4], 1);
        f0 = frames;
        repeat (40) @(negedge clk);
        chk("R2 disabled no frame", frames - f0, 0);
        chk("R2 disabled sclk low", sclk, 0);
        wr(3'd0, mkctrl(7, 1, 0, 0, 1, 0));
        wait_idle();
        chk("R5 ninth write dropped", frames - f0, 8);
        chk("R5 fifo order last", last_mosi, 16'h0017);
        rd(3'd3, v);
        chk("R7 rx full", v[3], 1);
        chk("R8 rx level", v[6], 1);
        chk("R9 no overrun yet", v[7], 0);
        chk("R10 irq masked ovr only", irq, 0);
        wr(3'd2, 16'h0055);
        wait_idle();
        chk("R9 extra frame sent", frames - f0, 9);
        rd(3'd3, v); chk("R9 overrun set", v[7], 1);
        chk("R10 irq from overrun", irq, 1);
        rd(3'd4, v); chk("R10 pending bits", v, 16'h0004);
        for (int i = 0; i < 8; i++) begin
            rd(3'd2, v); chk("R9 kept words", v, pat(f0 + i) & 16'h00FF);
        end
        rd(3'd2, v); chk("R9 overrun word discarded", v, 0);
        rd(3'd3, v); chk("R9 sticky after drain", v[7], 1);
        wr(3'd4, 16'h0000);
        rd(3'd3, v); chk("R9 cleared", v[7], 0);
        chk("R10 irq low after clear", irq, 0);
    endtask

    task automatic t_levels();
        logic [15:0] v;
        int f0;
        cur_len = 8;
        wr(3'd0, mkctrl(7, 0, 1, 0, 0, 0));
        chk("R8 tx level when empty", irq, 1);
        rd(3'd4, v); chk("R10 tx pending bit", v, 16'h0001);
        for (int i = 0; i < 4; i++) wr(3'd2, 16'h0020 + 16'(i));
        chk("R8 tx level at 4", irq, 1);
        wr(3'd2, 16'h0024);
        chk("R8 tx level off at 5", irq, 0);
        f0 = frames;
        wr(3'd0, mkctrl(7, 1, 0, 1, 0, 0));
        wait_idle();
        chk("R8 rx level at 5", irq, 1);
        rd(3'd4, v); chk("R10 rx pending bit", v, 16'h0002);
        rd(3'd2, v); chk("R5 order 0", v, pat(f0) & 16'h00FF);
        chk("R8 rx level at 4", irq, 1);
        rd(3'd2, v); chk("R5 order 1", v, pat(f0 + 1) & 16'h00FF);
        chk("R8 rx level off at 3", irq, 0);
        for (int i = 2; i < 5; i++) begin
            rd(3'd2, v); chk("R5 order rest", v, pat(f0 + i) & 16'h00FF);
        end
        wr(3'd0, mkctrl(7, 0, 0, 0, 0, 0));
    endtask

    task automatic t_disable();
        logic [15:0] v;
        int f0;
        cur_len = 8;
        wr(3'd1, 16'd4);
        wr(3'd0, mkctrl(7, 0, 0, 0, 0, 1));
        wr(3'd2, 16'h0061); wr(3'd2, 16'h0062); wr(3'd2, 16'h0063);
        f0 = frames;
        wr(3'd0, mkctrl(7, 1, 0, 0, 0, 1));
        @(posedge sclk);
        wr(3'd0, mkctrl(7, 0, 0, 0, 0, 1));
        repeat (300) @(negedge clk);
        chk("R11 current frame finished", frames - f0, 1);
        chk("R11 first word", last_mosi, 16'h0061);
        rd(3'd3, v);
        chk("R11 busy with held words", v[4], 1);
        chk("R11 tx not empty", v[0], 0);
        chk("R11 sclk low", sclk, 0);
        wr(3'd0, mkctrl(7, 1, 0, 0, 0, 1));
        wait_idle();
        chk("R11 resumed frames", frames - f0, 3);
        chk("R11 order kept", last_mosi, 16'h0063);
        for (int i = 0; i < 3; i++) begin
            rd(3'd2, v); chk("R11 rx words", v, pat(f0 + i) & 16'h00FF);
        end
        wr(3'd1, 16'd2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lengths();
        t_rate();
        t_overrun();
        t_levels();
        t_disable();
        summary();
        $finish;
    end
endmodule